// File: doc/BRIEF.md
# Scoreboard Issue and Completion Control

This block is the control core of a scoreboard that sits beside a few functional units. For each unit it keeps a status entry: busy flag, operation, destination register, two source registers, the tag of the unit that will produce each source, and a ready flag for each source. A register-result table records which unit, if any, will write each architectural register. Tags are one-based, and the value 0 means that no unit owns the register.

An instruction asks to issue to a named unit. The block grants the issue only when that unit is idle and no result is pending for the destination register. This covers both the structural hazard and the WAW hazard. Once both sources of a unit are ready, the block grants that unit's operand read. Execution is external. The unit reports completion on a done pulse, and the block holds the pulse until it grants the write. The block holds a write back while any other unit still has an unread source that names the finishing unit's destination, which is the WAR hazard. On a write, the block marks every waiting source ready and releases the unit and its table entry.

Top module: `sb_ctrl`

## Requirements
- R1: After reset, no unit is busy and the result table is empty. Any issue request is granted, and no read or write grant is raised.
- R2: An issue request naming a busy unit gets no grant.
- R3: An issue request whose destination register has a pending producer gets no grant.
- R4: A source that names a register with a pending producer keeps the unit's read grant low. The read grant comes in the cycle after that producer's write grant, provided the other source is ready.
- R5: When both sources have no pending producer at issue, the unit's read grant is raised in the cycle after the issue.
- R6: The read grant for one issued instruction lasts exactly one cycle.
- R7: A unit's write grant is held low while any other unit has a source equal to its destination that is ready but not yet read.
- R8: A single-cycle exec_done pulse is remembered. The write grant follows in the next cycle when no hazard blocks it.
- R9: At most one write grant is raised per cycle. Among the units allowed to write, the lowest index wins. Units are indexed 0 integer, 1 multiply, 2 add, 3 divide, and wr_grant bit i belongs to unit i.
- R10: A write grant frees the unit and its destination register. The following cycle, an issue to that unit or to that register can be granted.
- R11: An issue whose source is written in the same cycle treats that source as ready, so the read grant follows the next cycle.
- R12: unit_op, unit_src1 and unit_src2 hold, in field i, the values issued to unit i. wr_dst shows the destination register of the unit holding the write grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Issue request present |
| iss_unit | input | 2 | Target unit index |
| iss_op | input | 4 | Operation code |
| iss_dst | input | 4 | Destination register |
| iss_src1 | input | 4 | First source register |
| iss_src2 | input | 4 | Second source register |
| iss_grant | output | 1 | Issue accepted in this cycle |
| exec_done | input | 4 | Per-unit execution-finished pulse |
| rd_grant | output | 4 | Per-unit operand read permission |
| wr_grant | output | 4 | One-hot result write permission |
| wr_dst | output | 4 | Destination register of the granted write |
| unit_op | output | 16 | Per-unit operation, 4 bits per unit |
| unit_src1 | output | 16 | Per-unit first source, 4 bits per unit |
| unit_src2 | output | 16 | Per-unit second source, 4 bits per unit |

## Verification
A corrupted busy flag or result-table entry shows up at iss_grant in the same cycle as the next request that touches that unit or register. It appears either as a refused issue that should pass or as a granted issue that should stall. A stale tag or ready flag shows up at rd_grant within one cycle of the producer's write: the read grant is missing, comes early, or repeats. A broken WAR check or done latch shows as wr_grant arriving a cycle early, never arriving, or picking the wrong unit when two finish together.

// File: rtl/sb_pkg.sv
// Package sb_pkg: shared defaults, unit naming and tag sizing for the
// scoreboard control. Assumes unit tags are one-based with 0 meaning "none".
package sb_pkg;

    localparam int SB_NUM_FU  = 4;
    localparam int SB_NUM_REG = 16;
    localparam int SB_OP_W    = 4;

    // Default unit numbering; the index is also the write priority order.
    typedef enum logic [1:0] {
        U_INT = 2'd0,
        U_MUL = 2'd1,
        U_ADD = 2'd2,
        U_DIV = 2'd3
    } unit_id_e;

    // Bits needed to hold tags 0..n (0 = no producer).
    function automatic int tag_bits(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/sb_result_table.sv
// Module sb_result_table: register-result table. One entry per register
// holds the tag of the unit that will write it, or 0. Assumes set and clear
// never name the same register in one cycle (issue is refused on WAW).
module sb_result_table #(
    parameter int NUM_REG = 16,
    parameter int TAG_W   = 3,
    localparam int REG_W  = $clog2(NUM_REG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [REG_W-1:0] set_reg,
    input  logic [TAG_W-1:0] set_tag,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_reg,
    output logic [TAG_W-1:0] ent_o [NUM_REG]
);

    logic [TAG_W-1:0] ent [NUM_REG];

    // Update entries: clear on write, record producer on issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REG; r++) ent[r] <= '0;
        end else begin
            if (clr_en) ent[clr_reg] <= '0;
            if (set_en) ent[set_reg] <= set_tag;
        end
    end

    // Expose the table for lookups.
    always_comb begin
        for (int r = 0; r < NUM_REG; r++) ent_o[r] = ent[r];
    end

endmodule

// File: rtl/sb_unit_entry.sv
// Module sb_unit_entry: status entry of one functional unit. Holds busy,
// operation, destination, sources, producer tags, ready flags and the latched
// done flag. Assumes exec_done is only pulsed after the operand read.
module sb_unit_entry #(
    parameter int REG_W  = 4,
    parameter int TAG_W  = 3,
    parameter int OP_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_en,
    input  logic [OP_W-1:0]  op_in,
    input  logic [REG_W-1:0] dst_in,
    input  logic [REG_W-1:0] s1_in,
    input  logic [REG_W-1:0] s2_in,
    input  logic [TAG_W-1:0] q1_in,
    input  logic [TAG_W-1:0] q2_in,
    input  logic             read_en,
    input  logic             exec_done,
    input  logic             write_en,
    input  logic             bcast_en,
    input  logic [TAG_W-1:0] bcast_tag,
    output logic             busy,
    output logic [OP_W-1:0]  op_q,
    output logic [REG_W-1:0] fi,
    output logic [REG_W-1:0] fj,
    output logic [REG_W-1:0] fk,
    output logic             rj,
    output logic             rk,
    output logic             done_q
);

    logic [TAG_W-1:0] qj, qk;

    // Busy and done flags: set on issue / completion, cleared on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done_q <= 1'b0;
        end else if (issue_en) begin
            busy   <= 1'b1;
            done_q <= 1'b0;
        end else if (write_en) begin
            busy   <= 1'b0;
            done_q <= 1'b0;
        end else if (exec_done && busy) begin
            done_q <= 1'b1;
        end
    end

    // Static fields captured at issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= '0;
            fi   <= '0;
            fj   <= '0;
            fk   <= '0;
        end else if (issue_en) begin
            op_q <= op_in;
            fi   <= dst_in;
            fj   <= s1_in;
            fk   <= s2_in;
        end
    end

    // First source: producer tag and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qj <= '0;
            rj <= 1'b0;
        end else if (issue_en) begin
            qj <= q1_in;
            rj <= (q1_in == '0);
        end else if (read_en) begin
            rj <= 1'b0;
        end else if (bcast_en && busy && qj != '0 && qj == bcast_tag) begin
            qj <= '0;
            rj <= 1'b1;
        end
    end

    // Second source: producer tag and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qk <= '0;
            rk <= 1'b0;
        end else if (issue_en) begin
            qk <= q2_in;
            rk <= (q2_in == '0);
        end else if (read_en) begin
            rk <= 1'b0;
        end else if (bcast_en && busy && qk != '0 && qk == bcast_tag) begin
            qk <= '0;
            rk <= 1'b1;
        end
    end

endmodule

// File: rtl/sb_low_pick.sv
// Module sb_low_pick: fixed-priority picker, lowest requesting index wins.
// Produces a one-hot grant, its index and an any-grant flag.
module sb_low_pick #(
    parameter int N      = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    // Scan from the top so the lowest request is the last to assign.
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IDX_W'(i);
                any    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sb_ctrl.sv
// Module sb_ctrl: scoreboard issue, operand-read and write-result control.
// Issue waits on structural and WAW hazards, reads wait on RAW, writes wait
// on WAR. Assumes NUM_REG is a power of two and at most one issue request
// per cycle; unit i owns tag i+1.
module sb_ctrl #(
    parameter int NUM_FU  = sb_pkg::SB_NUM_FU,
    parameter int NUM_REG = sb_pkg::SB_NUM_REG,
    parameter int OP_W    = sb_pkg::SB_OP_W,
    localparam int REG_W  = $clog2(NUM_REG),
    localparam int UNIT_W = (NUM_FU > 1) ? $clog2(NUM_FU) : 1,
    localparam int TAG_W  = sb_pkg::tag_bits(NUM_FU)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    iss_valid,
    input  logic [UNIT_W-1:0]       iss_unit,
    input  logic [OP_W-1:0]         iss_op,
    input  logic [REG_W-1:0]        iss_dst,
    input  logic [REG_W-1:0]        iss_src1,
    input  logic [REG_W-1:0]        iss_src2,
    output logic                    iss_grant,
    input  logic [NUM_FU-1:0]       exec_done,
    output logic [NUM_FU-1:0]       rd_grant,
    output logic [NUM_FU-1:0]       wr_grant,
    output logic [REG_W-1:0]        wr_dst,
    output logic [NUM_FU*OP_W-1:0]  unit_op,
    output logic [NUM_FU*REG_W-1:0] unit_src1,
    output logic [NUM_FU*REG_W-1:0] unit_src2
);

    logic [NUM_FU-1:0] busy, rj, rk, done_q, war_ok;
    logic [OP_W-1:0]   opq [NUM_FU];
    logic [REG_W-1:0]  fi  [NUM_FU];
    logic [REG_W-1:0]  fj  [NUM_FU];
    logic [REG_W-1:0]  fk  [NUM_FU];
    logic [TAG_W-1:0]  tbl [NUM_REG];

    logic [UNIT_W-1:0] wr_idx;
    logic              wr_any;
    logic [TAG_W-1:0]  wr_tag, iss_tag, q1_raw, q2_raw, q1_fwd, q2_fwd;

    // Issue decision: unit idle and destination not pending.
    always_comb begin
        iss_grant = iss_valid && !busy[iss_unit] && (tbl[iss_dst] == '0);
        iss_tag   = TAG_W'(iss_unit) + TAG_W'(1);
    end

    // Producer lookup with same-cycle write forwarding.
    always_comb begin
        wr_tag = TAG_W'(wr_idx) + TAG_W'(1);
        q1_raw = tbl[iss_src1];
        q2_raw = tbl[iss_src2];
        q1_fwd = (wr_any && q1_raw == wr_tag) ? '0 : q1_raw;
        q2_fwd = (wr_any && q2_raw == wr_tag) ? '0 : q2_raw;
    end

    sb_result_table #(
        .NUM_REG (NUM_REG),
        .TAG_W   (TAG_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (iss_grant),
        .set_reg (iss_dst),
        .set_tag (iss_tag),
        .clr_en  (wr_any),
        .clr_reg (wr_dst),
        .ent_o   (tbl)
    );

    genvar u, f;
    generate
        for (u = 0; u < NUM_FU; u++) begin : g_unit
            logic [NUM_FU-1:0] clash;

            sb_unit_entry #(
                .REG_W (REG_W),
                .TAG_W (TAG_W),
                .OP_W  (OP_W)
            ) u_entry (
                .clk       (clk),
                .rst_n     (rst_n),
                .issue_en  (iss_grant && (iss_unit == UNIT_W'(u))),
                .op_in     (iss_op),
                .dst_in    (iss_dst),
                .s1_in     (iss_src1),
                .s2_in     (iss_src2),
                .q1_in     (q1_fwd),
                .q2_in     (q2_fwd),
                .read_en   (rd_grant[u]),
                .exec_done (exec_done[u]),
                .write_en  (wr_grant[u]),
                .bcast_en  (wr_any),
                .bcast_tag (wr_tag),
                .busy      (busy[u]),
                .op_q      (opq[u]),
                .fi        (fi[u]),
                .fj        (fj[u]),
                .fk        (fk[u]),
                .rj        (rj[u]),
                .rk        (rk[u]),
                .done_q    (done_q[u])
            );

            // WAR check against every other unit's unread sources.
            for (f = 0; f < NUM_FU; f++) begin : g_peer
                if (f == u) begin : g_self
                    assign clash[f] = 1'b0;
                end else begin : g_other
                    assign clash[f] = (fj[f] == fi[u] && rj[f]) ||
                                      (fk[f] == fi[u] && rk[f]);
                end
            end

            assign war_ok[u]   = ~|clash;
            assign rd_grant[u] = busy[u] && rj[u] && rk[u];
            assign unit_op  [u*OP_W  +: OP_W]  = opq[u];
            assign unit_src1[u*REG_W +: REG_W] = fj[u];
            assign unit_src2[u*REG_W +: REG_W] = fk[u];
        end
    endgenerate

    sb_low_pick #(
        .N (NUM_FU)
    ) u_pick (
        .req (done_q & busy & war_ok),
        .gnt (wr_grant),
        .idx (wr_idx),
        .any (wr_any)
    );

    // Destination of the granted writer.
    assign wr_dst = fi[wr_idx];

endmodule

// File: rtl/sb_ctrl_chk.sv
// Module sb_ctrl_chk: protocol checker for sb_ctrl, attached by bind.
// Observes ports plus the busy vector and result table.
module sb_ctrl_chk #(
    parameter int NUM_FU  = 4,
    parameter int NUM_REG = 16,
    parameter int UNIT_W  = 2,
    parameter int REG_W   = 4,
    parameter int TAG_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              iss_valid,
    input logic [UNIT_W-1:0] iss_unit,
    input logic [REG_W-1:0]  iss_dst,
    input logic              iss_grant,
    input logic [NUM_FU-1:0] rd_grant,
    input logic [NUM_FU-1:0] wr_grant,
    input logic [NUM_FU-1:0] busy,
    input logic [TAG_W-1:0]  tbl [NUM_REG]
);

    logic dst_pending;
    assign dst_pending = (tbl[iss_dst] != '0);

    AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_grant)); // R9

    AST_ISSUE_STRUCT: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && busy[iss_unit]) |-> !iss_grant); // R2

    AST_ISSUE_WAW: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && dst_pending) |-> !iss_grant); // R3

    AST_ISSUE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        iss_grant |=> busy[$past(iss_unit)]); // R2

    genvar i;
    generate
        for (i = 0; i < NUM_FU; i++) begin : g_u
            AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
                rd_grant[i] |=> !rd_grant[i]); // R6

            AST_RD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
                rd_grant[i] |-> busy[i]); // R4

            AST_WR_FREES: assert property (@(posedge clk) disable iff (!rst_n)
                wr_grant[i] |=> !busy[i]); // R10
        end
    endgenerate

endmodule

bind sb_ctrl sb_ctrl_chk #(
    .NUM_FU  (NUM_FU),
    .NUM_REG (NUM_REG),
    .UNIT_W  (UNIT_W),
    .REG_W   (REG_W),
    .TAG_W   (TAG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_unit  (iss_unit),
    .iss_dst   (iss_dst),
    .iss_grant (iss_grant),
    .rd_grant  (rd_grant),
    .wr_grant  (wr_grant),
    .busy      (busy),
    .tbl       (tbl)
);

// File: tb/sb_ctrl_test.sv
// Bench for sb_ctrl: table-driven hazard scenario, then directed tests for
// forwarding, field outputs and reset.
module sb_ctrl_test;
    import sb_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [1:0]  iss_unit = '0;
    logic [3:0]  iss_op = '0, iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
    logic        iss_grant;
    logic [3:0]  exec_done = '0, rd_grant, wr_grant, wr_dst;
    logic [15:0] unit_op, unit_src1, unit_src2;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    sb_ctrl uut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_unit(iss_unit),
        .iss_op(iss_op), .iss_dst(iss_dst), .iss_src1(iss_src1),
        .iss_src2(iss_src2), .iss_grant(iss_grant), .exec_done(exec_done),
        .rd_grant(rd_grant), .wr_grant(wr_grant), .wr_dst(wr_dst),
        .unit_op(unit_op), .unit_src1(unit_src1), .unit_src2(unit_src2)
    );

    typedef struct packed {
        logic       v;
        logic [1:0] u;
        logic [3:0] d, s1, s2, done;
        logic       e_iss;
        logic [3:0] e_rd, e_wr;
        logic [3:0] rq;
    } vec_t;

    // One row per cycle: request, done pulse, expected grants, requirement.
    localparam vec_t VEC [16] = '{
        '{1'b1, 2'd1, 4'd2, 4'd0, 4'd1, 4'h0, 1'b1, 4'h0, 4'h0, 4'd5},  // R5 mul issue
        '{1'b1, 2'd2, 4'd3, 4'd2, 4'd4, 4'h0, 1'b1, 4'h2, 4'h0, 4'd5},  // R5 mul reads
        '{1'b1, 2'd1, 4'd5, 4'd0, 4'd0, 4'h2, 1'b0, 4'h0, 4'h0, 4'd2},  // R2 mul busy
        '{1'b1, 2'd0, 4'd2, 4'd1, 4'd1, 4'h0, 1'b0, 4'h0, 4'h2, 4'd3},  // R3 r2 pending
        '{1'b1, 2'd0, 4'd2, 4'd3, 4'd3, 4'h0, 1'b1, 4'h4, 4'h0, 4'd4},  // R4 add now ready
        '{1'b1, 2'd3, 4'd6, 4'd9, 4'd3, 4'h0, 1'b1, 4'h0, 4'h0, 4'd6},  // R6 add read once
        '{1'b1, 2'd1, 4'd9, 4'd0, 4'd0, 4'h0, 1'b1, 4'h0, 4'h0, 4'd10}, // R10 mul reissued
        '{1'b0, 2'd0, 4'd0, 4'd0, 4'd0, 4'h0, 1'b0, 4'h2, 4'h0, 4'd5},  // R5
        '{1'b0, 2'd0, 4'd0, 4'd0, 4'd0, 4'h2, 1'b0, 4'h0, 4'h0, 4'd8},  // R8 pulse
        '{1'b0, 2'd0, 4'd0, 4'd0, 4'd0, 4'h4, 1'b0, 4'h0, 4'h0, 4'd7},  // R7 mul held
        '{1'b0, 2'd0, 4'd0, 4'd0, 4'd0, 4'h0, 1'b0, 4'h0, 4'h4, 4'd8},  // R8 add writes
        '{1'b0, 2'd0, 4'd0, 4'd0, 4'd0, 4'h0, 1'b0, 4'h9, 4'h0, 4'd4},  // R4 int+div read
        '{1'b0, 2'd0, 4'd0, 4'd0, 4'd0, 4'h9, 1'b0, 4'h0, 4'h2, 4'd7},  // R7 released
        '{1'b0, 2'd0, 4'd0, 4'd0, 4'd0, 4'h0, 1'b0, 4'h0, 4'h1, 4'd9},  // R9 int first
        '{1'b0, 2'd0, 4'd0, 4'd0, 4'd0, 4'h0, 1'b0, 4'h0, 4'h8, 4'd9},  // R9 div next
        '{1'b0, 2'd0, 4'd0, 4'd0, 4'd0, 4'h0, 1'b0, 4'h0, 4'h0, 4'd10}  // R10 idle
    };

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] u, input logic [3:0] op,
                         input logic [3:0] d, input logic [3:0] s1,
                         input logic [3:0] s2, input logic [3:0] dn);
        iss_valid = v; iss_unit = u; iss_op = op; iss_dst = d;
        iss_src1 = s1; iss_src2 = s2; exec_done = dn;
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state seen at the ports (request withdrawn before edge).
        drive(1'b1, U_DIV, 4'h0, 4'd0, 4'd0, 4'd0, 4'h0);
        #1;
        chk("R1", "iss_grant after reset", 32'(iss_grant), 32'd1);
        chk("R1", "rd_grant after reset", 32'(rd_grant), 32'h0);
        chk("R1", "wr_grant after reset", 32'(wr_grant), 32'h0);
        drive(1'b0, U_INT, 4'h0, 4'd0, 4'd0, 4'd0, 4'h0);

        // Table-driven hazard scenario.
        for (int k = 0; k < 16; k++) begin
            string rq;
            @(negedge clk);
            drive(VEC[k].v, VEC[k].u, 4'(k), VEC[k].d, VEC[k].s1, VEC[k].s2, VEC[k].done);
            #1;
            rq = $sformatf("R%0d", VEC[k].rq);
            chk(rq, $sformatf("row %0d iss_grant", k), 32'(iss_grant), 32'(VEC[k].e_iss));
            chk(rq, $sformatf("row %0d rd_grant", k), 32'(rd_grant), 32'(VEC[k].e_rd));
            chk(rq, $sformatf("row %0d wr_grant", k), 32'(wr_grant), 32'(VEC[k].e_wr));
        end

        // R11: forwarding of a source written in the issue cycle.
        @(negedge clk);
        drive(1'b1, U_ADD, 4'hA, 4'd4, 4'd0, 4'd0, 4'h0);
        #1 chk("R11", "add issue", 32'(iss_grant), 32'd1);
        @(negedge clk);
        drive(1'b0, U_INT, 4'h0, 4'd0, 4'd0, 4'd0, 4'h4);
        #1 chk("R5", "add read", 32'(rd_grant), 32'h4);
        @(negedge clk);
        drive(1'b1, U_DIV, 4'h5, 4'd7, 4'd4, 4'd4, 4'h0);
        #1;
        chk("R11", "div issue during add write", 32'(iss_grant), 32'd1);
        chk("R8", "add write", 32'(wr_grant), 32'h4);
        chk("R12", "wr_dst", 32'(wr_dst), 32'd4);
        @(negedge clk);
        drive(1'b0, U_INT, 4'h0, 4'd0, 4'd0, 4'd0, 4'h0);
        #1;
        chk("R11", "div reads next cycle", 32'(rd_grant), 32'h8);
        chk("R12", "div op field", 32'(unit_op[12 +: 4]), 32'h5);
        chk("R12", "div src1 field", 32'(unit_src1[12 +: 4]), 32'd4);
        chk("R12", "div src2 field", 32'(unit_src2[12 +: 4]), 32'd4);
        @(negedge clk);
        drive(1'b0, U_INT, 4'h0, 4'd0, 4'd0, 4'd0, 4'h8);
        #1 chk("R6", "no repeat read", 32'(rd_grant), 32'h0);
        @(negedge clk);
        drive(1'b0, U_INT, 4'h0, 4'd0, 4'd0, 4'd0, 4'h0);
        #1;
        chk("R8", "div write", 32'(wr_grant), 32'h8);
        chk("R12", "div wr_dst", 32'(wr_dst), 32'd7);

        // R1: reset while busy clears unit and table.
        @(negedge clk);
        drive(1'b1, U_INT, 4'h1, 4'd5, 4'd0, 4'd0, 4'h0);
        #1 chk("R1", "int issue", 32'(iss_grant), 32'd1);
        @(negedge clk);
        #1 chk("R2", "int busy refuses", 32'(iss_grant), 32'd0);
        drive(1'b0, U_INT, 4'h0, 4'd0, 4'd0, 4'd0, 4'h0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, U_MUL, 4'h1, 4'd5, 4'd0, 4'd0, 4'h0);
        #1 chk("R1", "r5 free after reset", 32'(iss_grant), 32'd1);
        drive(1'b1, U_INT, 4'h1, 4'd6, 4'd0, 4'd0, 4'h0);
        #1;
        chk("R1", "int free after reset", 32'(iss_grant), 32'd1);
        chk("R1", "no read after reset", 32'(rd_grant), 32'h0);
        chk("R1", "no write after reset", 32'(wr_grant), 32'h0);
        drive(1'b0, U_INT, 4'h0, 4'd0, 4'd0, 4'd0, 4'h0);
        @(negedge clk);

        summary();
    end

endmodule